// File: doc/BRIEF.md
# Bus-Mapped Successive-Approximation Converter Controller

This block is the digital side of a 10-bit successive-approximation converter that a processor addresses like a memory location. The processor starts a conversion by writing to it and collects the result by reading from it. All three bus strobes are active low, and a write or read counts only while the select line is also low. The rising edge of a qualified write freezes the analog front end through a hold output. The controller then resolves one bit of a trial code for each pulse of a conversion-clock enable. It works from the most significant bit down, and it consults a single comparator bit at each step. When the last bit is settled, the code is copied into a result latch and an active-low completion flag drops.

A qualified read places the latch contents on the data outputs and asserts an output-enable. The tri-state pad buffer that sits outside this block uses that enable. The falling edge of the read raises the completion flag again, and at that moment the front end goes back to tracking the input. The analog parts are outside the block: the DAC takes the trial code, the comparator returns its verdict, and the sample/hold obeys the hold line. Clocking is also outside the block and reaches it as the single enable input.

Top module: `sar_busctl`

## Requirements
- R1: A write or read strobe given while `cs_n` is high has no effect: `hold` stays low, `eoc_n` keeps its value and `rd_data_oe` stays low.
- R2: A conversion starts on the rising edge of `wr_n` while `cs_n` is low. `hold` is high from the next cycle until the completion flag is released, so the sampled input is frozen for the whole conversion.
- R3: The first trial code is 10'h200, which has only bit 9 set. Each `conv_en` pulse during a conversion settles one bit, MSB first, and exactly 10 pulses complete a conversion. The trial code does not change in a cycle without `conv_en`.
- R4: The conversion step that settles bit 0 also loads the result latch and drives `eoc_n` low.
- R5: The result latch keeps its value until the next conversion completes. Repeated reads return the same code even when the analog input has changed in between.
- R6: While `cs_n` and `rd_n` are both low, `rd_data_oe` is high and `rd_data` carries the latch, two clocks after the strobes are sampled. At all other times `rd_data_oe` is low and `rd_data` is zero.
- R7: The falling edge of a qualified read drives `eoc_n` high, and `hold` drops with it unless a conversion is running.
- R8: The result uses binary weights, with `rd_data[0]` as the LSB and `rd_data[9]` as the MSB. It is the largest code whose DAC level does not exceed the input. An input at or above full scale gives 10'h3FF, and an input at or below zero gives 10'h000. `cmp_hi` is 1 when the DAC level is above the input.
- R9: A qualified write rising edge that arrives while a conversion is running is ignored. The conversion still takes 10 steps and returns the code of the input held at its start.
- R10: After reset `eoc_n` is high, `hold` is low, `rd_data_oe` is low and the result latch is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low select |
| wr_n | input | 1 | Active-low write strobe; its rising edge starts a conversion |
| rd_n | input | 1 | Active-low read strobe |
| conv_en | input | 1 | Conversion-clock enable, one bit settled per pulse |
| cmp_hi | input | 1 | Comparator verdict: DAC level above the held input |
| dac_code | output | 10 | Trial code driven to the DAC |
| hold | output | 1 | 1 = sample/hold in hold, 0 = tracking |
| eoc_n | output | 1 | Active-low completion flag |
| rd_data | output | 10 | Result latch contents for the data pads |
| rd_data_oe | output | 1 | Enable for the data pad tri-state buffers |

## Verification
The bench converts every input level from zero to full scale, plus levels beyond both rails. This exposes a controller that tests bits in the wrong order or keeps a bit the comparator rejected: such a design returns wrong codes at or near the rails. Each conversion's enable pulses are counted, so a design that spends one step too many or too few is caught, and so is a design that restarts when a second write arrives mid-conversion. During that second write the analog input is also changed, so a hold that lapses early or a restart both yield the wrong code. Reads without select, repeat reads after the input has moved, and stalled enables cover the cases where a design would release the flag too readily, re-latch data, or drift its trial code.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic {
    ST_TRACK = 1'b0,
    ST_CONV  = 1'b1
  } sar_state_e;
endpackage

// File: rtl/sar_strobe_gate.sv
// Samples the bus strobes once and turns them into qualified edge pulses.
module sar_strobe_gate (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic wr_n,
  input  logic rd_n,
  output logic start_p,
  output logic rd_fall_p,
  output logic rd_act
);
  logic cs_q, wr_q, rd_q;
  logic wr_act_d, rd_act_d;
  logic wr_act;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q     <= 1'b1;
      wr_q     <= 1'b1;
      rd_q     <= 1'b1;
      wr_act_d <= 1'b0;
      rd_act_d <= 1'b0;
    end else begin
      cs_q     <= cs_n;
      wr_q     <= wr_n;
      rd_q     <= rd_n;
      wr_act_d <= wr_act;
      rd_act_d <= rd_act;
    end
  end

  assign wr_act    = ~cs_q & ~wr_q;
  assign rd_act    = ~cs_q & ~rd_q;
  // write released while select still low: rising edge of the gated write
  assign start_p   = wr_act_d & wr_q & ~cs_q;
  assign rd_fall_p = rd_act & ~rd_act_d;
endmodule

// File: rtl/sar_engine.sv
// Bit-serial approximation register, MSB first, one bit per enable.
module sar_engine #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         step_en,
  input  logic         cmp_hi,
  output logic         busy,
  output logic [W-1:0] trial,
  output logic         done,
  output logic [W-1:0] result
);
  import sar_pkg::*;

  localparam int          IW      = (W > 1) ? $clog2(W) : 1;
  localparam logic [IW-1:0] IDX_TOP = IW'(W - 1);
  localparam logic [IW-1:0] IDX_ONE = IW'(1);
  localparam logic [W-1:0]  MSB_BIT = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0]  LSB_BIT = {{(W-1){1'b0}}, 1'b1};

  sar_state_e    state;
  logic [IW-1:0] idx;
  logic [W-1:0]  settled;

  always_comb begin
    settled = trial;
    if (cmp_hi) settled[idx] = 1'b0;
  end

  assign busy   = (state == ST_CONV);
  assign done   = busy & step_en & (idx == '0);
  assign result = settled;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_TRACK;
      trial <= '0;
      idx   <= '0;
    end else begin
      case (state)
        ST_TRACK: begin
          if (start) begin
            state <= ST_CONV;
            trial <= MSB_BIT;
            idx   <= IDX_TOP;
          end
        end
        ST_CONV: begin
          if (step_en) begin
            if (idx == '0) begin
              state <= ST_TRACK;
              trial <= settled;
            end else begin
              trial <= settled | (LSB_BIT << (idx - IDX_ONE));
              idx   <= idx - IDX_ONE;
            end
          end
        end
        default: state <= ST_TRACK;
      endcase
    end
  end
endmodule

// File: rtl/sar_busctl.sv
// Bus-mapped SAR controller: strobe gating, approximation engine, result latch.
module sar_busctl #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cs_n,
  input  logic         wr_n,
  input  logic         rd_n,
  input  logic         conv_en,
  input  logic         cmp_hi,
  output logic [W-1:0] dac_code,
  output logic         hold,
  output logic         eoc_n,
  output logic [W-1:0] rd_data,
  output logic         rd_data_oe
);
  logic         start_p, rd_fall_p, rd_act;
  logic         busy, done;
  logic [W-1:0] result;
  logic [W-1:0] latch_q;
  logic         eoc_q;

  sar_strobe_gate u_gate (
    .clk       (clk),
    .rst       (rst),
    .cs_n      (cs_n),
    .wr_n      (wr_n),
    .rd_n      (rd_n),
    .start_p   (start_p),
    .rd_fall_p (rd_fall_p),
    .rd_act    (rd_act)
  );

  sar_engine #(.W(W)) u_engine (
    .clk     (clk),
    .rst     (rst),
    .start   (start_p),
    .step_en (conv_en),
    .cmp_hi  (cmp_hi),
    .busy    (busy),
    .trial   (dac_code),
    .done    (done),
    .result  (result)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q    <= '0;
      eoc_q      <= 1'b1;
      rd_data    <= '0;
      rd_data_oe <= 1'b0;
    end else begin
      if (done) begin
        latch_q <= result;
        eoc_q   <= 1'b0;
      end else if (rd_fall_p) begin
        eoc_q   <= 1'b1;
      end
      rd_data_oe <= rd_act;
      rd_data    <= rd_act ? latch_q : '0;
    end
  end

  assign eoc_n = eoc_q;
  // front end holds while converting and until the flag is released
  assign hold  = busy | ~eoc_q;
endmodule

// File: rtl/sar_busctl_chk.sv
module sar_busctl_chk #(
  parameter int W = 10
) (
  input logic         clk,
  input logic         rst,
  input logic         cs_n,
  input logic         rd_n,
  input logic         conv_en,
  input logic [W-1:0] dac_code,
  input logic         hold,
  input logic         eoc_n,
  input logic [W-1:0] rd_data,
  input logic         rd_data_oe
);
  localparam logic [W-1:0] MSB_BIT = {1'b1, {(W-1){1'b0}}};

  p_reset_idle_r10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (eoc_n && !hold && !rd_data_oe));

  p_first_trial_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(hold) |-> (dac_code == MSB_BIT));

  p_trial_frozen_r3: assert property (@(posedge clk) disable iff (rst)
    (hold && eoc_n && !conv_en) |=> $stable(dac_code));

  p_done_on_step_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(eoc_n) |-> ($past(hold) && $past(conv_en)));

  p_release_by_read_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(eoc_n) |-> $past(!cs_n && !rd_n));

  p_oe_needs_select_r6: assert property (@(posedge clk) disable iff (rst)
    rd_data_oe |-> $past(!cs_n && !rd_n, 2));

  p_bus_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    !rd_data_oe |-> (rd_data == '0));
endmodule

bind sar_busctl sar_busctl_chk #(.W(W)) u_chk (.*);

// File: tb/sar_busctl_test.sv
`timescale 1ns/1ps
module sar_busctl_test;
  localparam int W    = 10;
  localparam int FULL = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1;
  logic         conv_en = 1'b0;
  logic         cmp_hi;
  logic [W-1:0] dac_code;
  logic         hold, eoc_n;
  logic [W-1:0] rd_data;
  logic         rd_data_oe;

  int vin = 0;
  int vheld = 0;
  int en_div = 1;
  int en_cnt = 0;
  int vectors = 0;
  int misses = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  sar_busctl #(.W(W)) uut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
    .conv_en(conv_en), .cmp_hi(cmp_hi), .dac_code(dac_code), .hold(hold),
    .eoc_n(eoc_n), .rd_data(rd_data), .rd_data_oe(rd_data_oe)
  );

  // ideal sample/hold and comparator
  always @(posedge clk) if (!hold) vheld <= vin;
  assign cmp_hi = (int'(dac_code) > (hold ? vheld : vin));

  always @(posedge clk) begin
    en_cnt  <= (en_cnt + 1 >= en_div) ? 0 : en_cnt + 1;
    conv_en <= (en_cnt == 0);
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int clamp(input int v);
    if (v < 0) return 0;
    if (v > FULL) return FULL;
    return v;
  endfunction

  // qualified write, then count enables until the flag drops
  task automatic convert(input int v, input bit intrude, input int other, output int steps);
    vin = v;
    @(negedge clk); cs_n = 1'b0; wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1;
    @(negedge clk); cs_n = 1'b1;
    steps = 0;
    for (int t = 0; t < 400; t++) begin
      @(negedge clk);
      if (!eoc_n) break;
      if (intrude) begin
        if (t == 6) begin cs_n = 1'b0; wr_n = 1'b0; vin = other; end
        if (t == 8) wr_n = 1'b1;
        if (t == 9) cs_n = 1'b1;
      end
      if (conv_en && hold) steps++;
    end
  endtask

  task automatic bus_read(output int val, output bit oe, output bit eoc_after, output bit hold_after);
    @(negedge clk); cs_n = 1'b0; rd_n = 1'b0;
    repeat (3) @(negedge clk);
    val = int'(rd_data); oe = rd_data_oe; eoc_after = eoc_n; hold_after = hold;
    rd_n = 1'b1; cs_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      misses++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    int steps, val, exp;
    bit oe, eo, ho;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check(eoc_n == 1'b1, "R10 eoc_n", int'(eoc_n), 1);
    check(hold == 1'b0, "R10 hold", int'(hold), 0);
    check(rd_data_oe == 1'b0, "R10 oe", int'(rd_data_oe), 0);

    // R1 write without select
    wr_n = 1'b0; repeat (2) @(negedge clk); wr_n = 1'b1;
    repeat (5) @(negedge clk);
    check(hold == 1'b0, "R1 write ignored hold", int'(hold), 0);
    check(eoc_n == 1'b1, "R1 write ignored eoc", int'(eoc_n), 1);

    // R10 latch zero on reset: first read before any conversion
    bus_read(val, oe, eo, ho);
    check(val == 0, "R10 latch", val, 0);
    check(oe == 1'b1, "R6 oe on read", int'(oe), 1);

    // R8/R3/R4/R6/R7 sweep over every level plus both rails
    for (int v = -3; v <= FULL + 3; v++) begin
      en_div = ((v & 63) == 5) ? 3 : 1;
      convert(v, 1'b0, 0, steps);
      exp = clamp(v);
      check(eoc_n == 1'b0, "R4 eoc low", int'(eoc_n), 0);
      check(steps == W, "R3 steps", steps, W);
      check(hold == 1'b1, "R2 hold until release", int'(hold), 1);
      check(rd_data_oe == 1'b0, "R6 idle oe", int'(rd_data_oe), 0);
      bus_read(val, oe, eo, ho);
      check(val == exp, "R8 code", val, exp);
      check(oe == 1'b1, "R6 oe", int'(oe), 1);
      check(eo == 1'b1, "R7 eoc release", int'(eo), 1);
      check(ho == 1'b0, "R7 track resumes", int'(ho), 0);
      check(rd_data_oe == 1'b0 && rd_data == '0, "R6 bus quiet", int'(rd_data), 0);
    end

    // R1 read without select keeps flag low; R5 repeat read holds
    en_div = 2;
    convert(700, 1'b0, 0, steps);
    @(negedge clk); rd_n = 1'b0;
    repeat (3) @(negedge clk);
    check(rd_data_oe == 1'b0, "R1 read ignored oe", int'(rd_data_oe), 0);
    check(eoc_n == 1'b0, "R1 read ignored eoc", int'(eoc_n), 0);
    rd_n = 1'b1;
    @(negedge clk);
    vin = 12;
    bus_read(val, oe, eo, ho);
    check(val == 700, "R5 first read", val, 700);
    vin = 300;
    repeat (5) @(negedge clk);
    bus_read(val, oe, eo, ho);
    check(val == 700, "R5 repeat read", val, 700);
    check(eo == 1'b1, "R5 flag stays released", int'(eo), 1);

    // R9 write during conversion ignored, input change masked by hold (R2)
    en_div = 3;
    convert(417, 1'b1, 90, steps);
    check(steps == W, "R9 steps", steps, W);
    bus_read(val, oe, eo, ho);
    check(val == 417, "R9 code", val, 417);

    // R3 slow enables
    en_div = 7;
    convert(513, 1'b0, 0, steps);
    check(steps == W, "R3 slow steps", steps, W);
    bus_read(val, oe, eo, ho);
    check(val == 513, "R3 slow code", val, 513);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule